// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block decides when a nonvolatile static memory copies its SRAM contents into the shadow nonvolatile array (a store) and when it copies that array back into SRAM (a recall). It also decides when ordinary SRAM accesses may proceed. Four sources can ask for work. A power-good rising event requests a recall. A power-fail comparator level requests an automatic store on its rising edge. A software unlock detector issues store and recall pulses. A shared open-drain store/busy line lets several devices store together. The line is modelled as a sampled "line is low" input and a "pull the line low" output.

A dirty flag records whether any SRAM write was accepted since the last store. Automatic stores and line-requested stores only copy the array when the flag is set. A software store always runs. The block pulls the shared line low for the whole of every store. After a store that the line requested, or after such a request was skipped, accesses stay blocked until the line is high again. All durations are parameters in clock cycles.

Top module: `nvseq_ctrl`

## Requirements
- R1: After synchronous active-low reset the block is idle: store_busy, recall_clear, recall_load and busy_drive_low are 0, and an access request is granted.
- R2: A pwr_good_rise pulse starts a recall. recall_clear is high for exactly one cycle, then recall_load is high for RECALL_CYCLES cycles. When other requests arrive in the same cycle, the recall wins and those requests are dropped.
- R3: A sw_store_req pulse in idle with pwr_fail low starts a store whether or not anything is dirty. store_busy is then high for exactly STORE_CYCLES cycles.
- R4: A granted write sets a dirty flag, and a completed store or recall clears it. Automatic and line-requested stores do not run (store_busy stays 0) while the flag is clear.
- R5: A rising edge of pwr_fail while dirty pulls the line low for one check cycle. The store follows only if busy_in_low is observed high (line low) at the end of that cycle. Otherwise the attempt is abandoned and the block returns to idle.
- R6: busy_in_low sampled high on ASSERT_CYCLES consecutive idle cycles opens a grace window of GRACE_CYCLES cycles, after which the conditional store starts. A shorter low pulse has no effect.
- R7: During the grace window, a continuing read (acc_req with acc_new=0, acc_wr=0) is granted. A new access (acc_new=1) or a write is not granted, and the store (or its skip) begins on the next cycle.
- R8: busy_drive_low is 1 in every cycle in which store_busy is 1.
- R9: After a line-requested store completes or is skipped, no access is granted while busy_in_low is 1. Accesses are granted again one cycle after it returns to 0.
- R10: While pwr_fail is 1, sw_store_req is ignored and a low line does not start the qualification.
- R11: No access is granted during a store or recall. Store and recall requests that arrive while one is in progress are dropped.
- R12: In idle, acc_grant equals acc_req in the same cycle (combinational).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good_rise | input | 1 | Single-cycle pulse: supply rose above the switch threshold |
| pwr_fail | input | 1 | Level: supply is below the switch threshold |
| sw_store_req | input | 1 | Single-cycle software store request |
| sw_recall_req | input | 1 | Single-cycle software recall request |
| busy_in_low | input | 1 | Shared store/busy line observed low |
| busy_drive_low | output | 1 | Pull the shared store/busy line low |
| acc_req | input | 1 | SRAM access present this cycle |
| acc_wr | input | 1 | The access is a write |
| acc_new | input | 1 | Address or control changed this cycle |
| acc_grant | output | 1 | Access allowed to proceed this cycle |
| store_busy | output | 1 | Store copy in progress |
| recall_clear | output | 1 | Recall phase one: clear the SRAM |
| recall_load | output | 1 | Recall phase two: load SRAM from nonvolatile copy |

## Verification
Random idle traffic of reads, writes and address changes is applied, and each burst ends with a line-requested store. Whether that store runs shows whether the dirty flag saw exactly the granted writes. Directed cases cover line pulses one cycle shorter than the qualifying time and line pulses that qualify. The grace window is tested both by letting it expire and by cutting it short with a write. Further cases check automatic stores with the line held high against those with the line free, requests made while the supply is failing, requests made during a store, and a recall arriving together with a store request. Store and recall lengths are measured in cycles.

// File: rtl/nvseq_pkg.sv
// Shared types for the store/recall sequencer.
package nvseq_pkg;
    typedef enum logic [2:0] {
        SQ_IDLE,    // normal SRAM operation
        SQ_RCLR,    // recall: clear SRAM
        SQ_RLOAD,   // recall: load SRAM from shadow copy
        SQ_ACHK,    // automatic store: line pulled, waiting to observe it
        SQ_GRACE,   // line-requested store: accesses may finish
        SQ_STORE,   // copying SRAM to shadow copy
        SQ_HOLD     // post-store inhibit until the line is released
    } seq_state_t;
endpackage

// File: rtl/nvseq_rise_det.sv
// Rising-edge detector for a level input.
// Assumes the input is already synchronous to clk.
module nvseq_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic lvl_q;

    // Remember last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/nvseq_low_qual.sv
// Qualifies the shared line: reports when it has been low on HOLD_CYCLES
// consecutive enabled cycles. Assumes line_low is synchronous to clk.
module nvseq_low_qual #(
    parameter int HOLD_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic line_low,
    output logic qualified
);
    localparam int QW = $clog2(HOLD_CYCLES + 1);
    localparam logic [QW-1:0] LAST = QW'(HOLD_CYCLES - 1);

    logic [QW-1:0] run_cnt;

    // Count consecutive low samples, restarting on any break.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || !line_low) run_cnt <= '0;
        else if (run_cnt != LAST)       run_cnt <= run_cnt + 1'b1;
    end

    assign qualified = en & line_low & (run_cnt == LAST);
endmodule

// File: rtl/nvseq_timer.sv
// Down-counter for phase lengths. A load of N makes `expired` true in the
// N-th cycle after the load. Assumes load values are at least 1.
module nvseq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Load or count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val - 1'b1;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/nvseq_ctrl.sv
// Store/recall sequencer for a nonvolatile static memory.
// Arbitrates power events, software requests and the shared store/busy
// line, tracks writes since the last store, and gates SRAM accesses.
// Assumes all inputs are synchronous to clk; pulses last one cycle.
module nvseq_ctrl #(
    parameter int STORE_CYCLES  = 64,
    parameter int RECALL_CYCLES = 16,
    parameter int ASSERT_CYCLES = 4,
    parameter int GRACE_CYCLES  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good_rise,
    input  logic pwr_fail,
    input  logic sw_store_req,
    input  logic sw_recall_req,
    input  logic busy_in_low,
    output logic busy_drive_low,
    input  logic acc_req,
    input  logic acc_wr,
    input  logic acc_new,
    output logic acc_grant,
    output logic store_busy,
    output logic recall_clear,
    output logic recall_load
);
    import nvseq_pkg::*;

    localparam int MAX_A = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;
    localparam int MAX_T = (MAX_A > GRACE_CYCLES) ? MAX_A : GRACE_CYCLES;
    localparam int TW    = $clog2(MAX_T + 1);

    seq_state_t   state, state_n;
    logic         from_line, from_line_n;
    logic         dirty;
    logic         pf_rise, line_qual, tmr_exp, tmr_load;
    logic [TW-1:0] tmr_val;
    logic         cut_grace;

    nvseq_rise_det u_pf_rise (
        .clk(clk), .rst_n(rst_n), .lvl(pwr_fail), .rise(pf_rise)
    );

    nvseq_low_qual #(.HOLD_CYCLES(ASSERT_CYCLES)) u_qual (
        .clk(clk), .rst_n(rst_n),
        .en((state == SQ_IDLE) & ~pwr_fail),
        .line_low(busy_in_low), .qualified(line_qual)
    );

    nvseq_timer #(.W(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .expired(tmr_exp)
    );

    assign cut_grace = acc_req & (acc_new | acc_wr);

    // Next-state selection with request priority.
    always_comb begin
        state_n     = state;
        from_line_n = from_line;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        unique case (state)
            SQ_IDLE: begin
                if (pwr_good_rise) begin
                    state_n = SQ_RCLR;
                end else if (pf_rise) begin
                    if (dirty) state_n = SQ_ACHK;
                end else if (line_qual) begin
                    state_n  = SQ_GRACE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(GRACE_CYCLES);
                end else if (sw_store_req && !pwr_fail) begin
                    state_n     = SQ_STORE;
                    from_line_n = 1'b0;
                    tmr_load    = 1'b1;
                    tmr_val     = TW'(STORE_CYCLES);
                end else if (sw_recall_req) begin
                    state_n = SQ_RCLR;
                end
            end
            SQ_RCLR: begin
                state_n  = SQ_RLOAD;
                tmr_load = 1'b1;
                tmr_val  = TW'(RECALL_CYCLES);
            end
            SQ_RLOAD: begin
                if (tmr_exp) state_n = SQ_IDLE;
            end
            SQ_ACHK: begin
                if (busy_in_low) begin
                    state_n     = SQ_STORE;
                    from_line_n = 1'b0;
                    tmr_load    = 1'b1;
                    tmr_val     = TW'(STORE_CYCLES);
                end else begin
                    state_n = SQ_IDLE;
                end
            end
            SQ_GRACE: begin
                if (pwr_good_rise) begin
                    state_n = SQ_RCLR;
                end else if (tmr_exp || cut_grace) begin
                    if (dirty) begin
                        state_n     = SQ_STORE;
                        from_line_n = 1'b1;
                        tmr_load    = 1'b1;
                        tmr_val     = TW'(STORE_CYCLES);
                    end else begin
                        state_n = SQ_HOLD;
                    end
                end
            end
            SQ_STORE: begin
                if (tmr_exp) state_n = from_line ? SQ_HOLD : SQ_IDLE;
            end
            SQ_HOLD: begin
                if (pwr_good_rise)     state_n = SQ_RCLR;
                else if (!busy_in_low) state_n = SQ_IDLE;
            end
            default: state_n = SQ_IDLE;
        endcase
    end

    // State and store-origin registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            from_line <= 1'b0;
        end else begin
            state     <= state_n;
            from_line <= from_line_n;
        end
    end

    // Dirty-since-last-store tracking.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dirty <= 1'b0;
        else if (((state == SQ_STORE) || (state == SQ_RLOAD)) && tmr_exp)
            dirty <= 1'b0;
        else if (acc_grant && acc_wr)
            dirty <= 1'b1;
    end

    // Access gating: free in idle, only continuing reads during grace.
    assign acc_grant = acc_req &
                       ((state == SQ_IDLE) ||
                        ((state == SQ_GRACE) && !acc_new && !acc_wr));

    assign busy_drive_low = (state == SQ_STORE) || (state == SQ_ACHK);
    assign store_busy     = (state == SQ_STORE);
    assign recall_clear   = (state == SQ_RCLR);
    assign recall_load    = (state == SQ_RLOAD);
endmodule

// File: rtl/nvseq_ctrl_chk.sv
// Property checker for nvseq_ctrl, attached by bind.
module nvseq_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic acc_req,
    input logic acc_grant,
    input logic busy_drive_low,
    input logic store_busy,
    input logic recall_clear,
    input logic recall_load
);
    AST_STORE_PULLS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        store_busy |-> busy_drive_low);                                   // R8
    AST_NO_ACCESS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (store_busy || recall_clear || recall_load) |-> !acc_grant);      // R11
    AST_CLEAR_THEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        recall_clear |=> recall_load);                                    // R2
    AST_ONE_OPERATION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({store_busy, recall_clear, recall_load}));               // R11
    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        acc_grant |-> acc_req);                                           // R12
endmodule

bind nvseq_ctrl nvseq_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_grant(acc_grant),
    .busy_drive_low(busy_drive_low), .store_busy(store_busy),
    .recall_clear(recall_clear), .recall_load(recall_load)
);

// File: tb/nvseq_ctrl_tb.sv
module nvseq_ctrl_tb;
    localparam int S = 64, RC = 16, A = 4, G = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good_rise = 0, pwr_fail = 0, sw_store_req = 0, sw_recall_req = 0;
    logic acc_req = 0, acc_wr = 0, acc_new = 0;
    logic ext_low = 0, hold_high = 0;
    logic busy_drive_low, acc_grant, store_busy, recall_clear, recall_load;
    logic busy_in_low;
    int   nchk = 0, nfail = 0, cyc = 0;

    always #5 clk = ~clk;

    // Open-drain line model; hold_high stands for a strong external pull-up.
    assign busy_in_low = hold_high ? 1'b0 : (ext_low | busy_drive_low);

    nvseq_ctrl #(.STORE_CYCLES(S), .RECALL_CYCLES(RC),
                 .ASSERT_CYCLES(A), .GRACE_CYCLES(G)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_good_rise(pwr_good_rise),
        .pwr_fail(pwr_fail), .sw_store_req(sw_store_req),
        .sw_recall_req(sw_recall_req), .busy_in_low(busy_in_low),
        .busy_drive_low(busy_drive_low), .acc_req(acc_req), .acc_wr(acc_wr),
        .acc_new(acc_new), .acc_grant(acc_grant), .store_busy(store_busy),
        .recall_clear(recall_clear), .recall_load(recall_load)
    );

    function automatic bit exp_store_runs(bit dirty, bit sw);
        return sw || dirty;
    endfunction

    function automatic bit exp_idle_grant(bit req);
        return req;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    // Count remaining store cycles, noting any cycle without the line pulled.
    task automatic run_store(output int len, output bit drv_ok);
        len = 0; drv_ok = 1'b1;
        while (store_busy && len < S + 10) begin
            if (!busy_drive_low) drv_ok = 1'b0;
            len++;
            tick();
        end
    endtask

    // Watch n cycles; returns 1 if store_busy was ever seen.
    task automatic watch_store(input int n, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (store_busy) seen = 1'b1;
            tick();
        end
    endtask

    task automatic write_once();
        acc_req = 1; acc_wr = 1; acc_new = 1;
        tick();
        acc_req = 0; acc_wr = 0; acc_new = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            nfail++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        int len; bit ok; bit seen; bit wrote; int k;
        void'($urandom(32'd4711));
        repeat (3) tick();
        rst_n = 1;
        tick();

        // R1 reset state
        chk({store_busy, recall_clear, recall_load, busy_drive_low} == 4'b0, "R1 idle outputs",
            {store_busy, recall_clear, recall_load, busy_drive_low}, 0);
        acc_req = 1; #1;
        chk(acc_grant == 1, "R1 grant after reset", acc_grant, 1);
        acc_req = 0;

        // R2 recall, with a simultaneous store request dropped
        pwr_good_rise = 1; sw_store_req = 1;
        tick();
        pwr_good_rise = 0; sw_store_req = 0;
        chk(recall_clear == 1 && store_busy == 0, "R2 clear phase first", recall_clear, 1);
        acc_req = 1; #1;
        chk(acc_grant == 0, "R11 no grant in recall", acc_grant, 0);
        acc_req = 0;
        tick();
        len = 0;
        while (recall_load && len < RC + 10) begin len++; tick(); end
        chk(len == RC, "R2 recall load length", len, RC);
        watch_store(6, seen);
        chk(!seen, "R2 recall wins over store", seen, 0);

        // R3 software store runs while clean; R8 line pulled throughout
        sw_store_req = 1; tick(); sw_store_req = 0;
        run_store(len, ok);
        chk(len == S, "R3 store length", len, S);
        chk(ok, "R8 line low during store", ok, 1);

        // R5 automatic store when dirty
        write_once();
        pwr_fail = 1; tick();
        chk(busy_drive_low == 1 && store_busy == 0, "R5 check cycle pulls line", busy_drive_low, 1);
        tick();
        chk(store_busy == 1, "R5 store after line seen low", store_busy, 1);
        run_store(len, ok);
        pwr_fail = 0; tick();

        // R4 automatic store skipped when clean
        pwr_fail = 1; tick();
        chk(busy_drive_low == 0, "R4 clean auto no pull", busy_drive_low, 0);
        watch_store(6, seen);
        chk(!seen, "R4 clean auto store skipped", seen, 0);
        pwr_fail = 0; tick();

        // R5 abort when line cannot be pulled low
        write_once();
        hold_high = 1; pwr_fail = 1; tick();
        chk(busy_drive_low == 1, "R5 attempt pulls line", busy_drive_low, 1);
        tick();
        chk(store_busy == 0 && busy_drive_low == 0, "R5 aborted attempt", store_busy, 0);
        watch_store(4, seen);
        chk(!seen, "R5 no store after abort", seen, 0);
        hold_high = 0; pwr_fail = 0; tick();

        // R6 short line pulse ignored (still dirty)
        ext_low = 1; repeat (A - 1) tick(); ext_low = 0;
        acc_req = 1; acc_wr = 1; acc_new = 1; #1;
        chk(acc_grant == 1, "R6 short pulse leaves idle", acc_grant, 1);
        tick(); acc_req = 0; acc_wr = 0; acc_new = 0;
        watch_store(A + G + 4, seen);
        chk(!seen, "R6 short pulse no store", seen, 0);

        // R6/R7 qualified pulse, grace expires, R9 inhibit until release
        ext_low = 1; repeat (A) tick();
        acc_req = 1; #1;
        chk(acc_grant == 1, "R7 continuing read in grace", acc_grant, 1);
        tick(); acc_req = 0;
        k = 0;
        while (!store_busy && k < G + 5) begin k++; tick(); end
        chk(k == G - 1, "R6 store after grace window", k, G - 1);
        run_store(len, ok);
        chk(ok && len == S, "R8 line-requested store", len, S);
        acc_req = 1; #1;
        chk(acc_grant == 0, "R9 inhibit while line low", acc_grant, 0);
        tick(); tick(); #1;
        chk(acc_grant == 0, "R9 inhibit persists", acc_grant, 0);
        ext_low = 0; tick(); #1;
        chk(acc_grant == 1, "R9 released after line high", acc_grant, 1);
        acc_req = 0;

        // R7 grace cut short by a write
        write_once();
        ext_low = 1; repeat (A) tick();
        acc_req = 1; acc_wr = 1; acc_new = 1; #1;
        chk(acc_grant == 0, "R7 write in grace discarded", acc_grant, 0);
        tick(); acc_req = 0; acc_wr = 0; acc_new = 0;
        chk(store_busy == 1, "R7 store starts at once", store_busy, 1);
        run_store(len, ok);
        ext_low = 0; tick();

        // R4/R9 clean line request skipped, device held until release
        ext_low = 1;
        watch_store(A + G + 4, seen);
        chk(!seen, "R4 clean line request skipped", seen, 0);
        acc_req = 1; #1;
        chk(acc_grant == 0, "R9 hold after skip", acc_grant, 0);
        ext_low = 0; tick(); #1;
        chk(acc_grant == 1, "R9 release after skip", acc_grant, 1);
        acc_req = 0;

        // R10 failing supply blocks software and line stores
        write_once();
        pwr_fail = 1; hold_high = 1; tick(); tick(); hold_high = 0;
        sw_store_req = 1; tick(); sw_store_req = 0;
        watch_store(4, seen);
        chk(!seen, "R10 software store ignored", seen, 0);
        ext_low = 1;
        watch_store(A + G + 4, seen);
        chk(!seen, "R10 line store ignored", seen, 0);
        acc_req = 1; #1;
        chk(acc_grant == 1, "R10 accesses continue", acc_grant, 1);
        acc_req = 0; ext_low = 0; pwr_fail = 0; tick();

        // R11 recall request during store dropped
        sw_store_req = 1; tick(); sw_store_req = 0;
        repeat (5) tick();
        sw_recall_req = 1; tick(); sw_recall_req = 0;
        run_store(len, ok);
        seen = 1'b0;
        for (int i = 0; i < 6; i++) begin if (recall_clear) seen = 1'b1; tick(); end
        chk(!seen, "R11 recall during store dropped", seen, 0);

        // R4 store clears dirty: following line request skipped
        write_once();
        sw_store_req = 1; tick(); sw_store_req = 0;
        run_store(len, ok);
        ext_low = 1;
        watch_store(A + G + 4, seen);
        chk(!seen, "R4 dirty cleared by store", seen, 0);
        ext_low = 0; tick();

        // Random idle traffic, then a line request (R12, R4)
        for (int r = 0; r < 20; r++) begin
            wrote = 1'b0;
            for (int i = 0; i < 40; i++) begin
                acc_req = 1'($urandom % 2);
                acc_wr  = ($urandom % 48) == 0;
                acc_new = 1'($urandom % 2);
                #1;
                chk(acc_grant == exp_idle_grant(acc_req), "R12 idle grant", acc_grant, acc_req);
                wrote = wrote | (acc_req & acc_wr);
                tick();
            end
            acc_req = 0; acc_wr = 0; acc_new = 0;
            ext_low = 1;
            watch_store(A + G + 2, seen);
            run_store(len, ok);
            chk(seen == exp_store_runs(wrote, 1'b0), "R4 store follows dirty", seen, wrote);
            ext_low = 0; tick(); tick();
        end

        summary();
        $finish;
    end
endmodule